// File: doc/BRIEF.md
# Multi-Lane Serial Flash Command Sequencer

This block is the controller side of a serial flash interface. It runs one command as a sequence of bytes in fixed order: instruction bytes, address bytes, outgoing payload bytes, turnaround (dummy) bytes and incoming read bytes. Each of these groups has a byte count of its own, and any count may be zero. A three-bit lane-plan code gives the number of data lanes (1, 2 or 4) for three groups: the instruction, the address/payload, and the dummy/read bytes. The lane count therefore changes in the middle of a command. The dummy clock count follows from the number of dummy bytes and the data lane count.

Outgoing instruction, address and payload bytes come from one show-ahead byte stream. The engine pulses `tx_pop` on each clock edge where it takes `wr_data`. If the configured mode byte is nonzero, it is sent as the first dummy byte. Incoming bytes appear on `rd_data`, each marked by a one-cycle `rd_valid`. The four lanes appear as separate output, output-enable and input vectors, so pad cells outside the block can join them. The serial clock runs at half the system clock in SPI mode 0.

Top module: `mio_spi_engine`

## Requirements
- R1: The `mode` code sets the lanes per group as instruction-address-data: 0 = 1-1-1, 1 = 1-1-2, 2 = 1-2-2, 3 = 1-1-4, 4 = 1-4-4, 5 = 4-4-4. Codes 6 and 7 behave as 0.
- R2: Payload bytes use the address-group lane count. In modes 1 and 3 they leave on lane 0 alone, while the read data uses the wider bus.
- R3: Bytes are shifted MSB first, and the highest-numbered active lane carries the highest bit of each group. With one lane, output is on lane 0 and input is taken from lane 1. Two lanes use lanes 1:0, and four lanes use lanes 3:0.
- R4: The dummy bytes take dummy_bytes*8/w rising SCK edges, where w is the data lane count: 1 in mode 0, 2 in modes 1 and 2, 4 in modes 3 to 5.
- R5: A nonzero `mode_byte` is driven as the first dummy byte at the data lane width. A zero `mode_byte` leaves every dummy byte undriven.
- R6: During dummy bytes all lanes are released and the sampled values are discarded. Each read byte is delivered exactly once on `rd_data` with a one-cycle `rd_valid`, in order.
- R7: A command makes (sum over its bytes of 8/lanes) rising SCK edges. A `start` with every count zero causes no bus activity, and `busy` stays low.
- R8: `cs_n` falls one clock before the first rising SCK edge and rises one clock after the last falling SCK edge. `busy` is high from the clock after `start` until `cs_n` rises: 2E+2 cycles for E rising edges, with `cs_n` low for 2E+1 cycles.
- R9: A `start` while `busy` is high is ignored. The running command keeps its latched settings, and no second command follows.
- R10: In any byte that the controller receives, all output enables are low before the first rising edge that samples it, and they stay low for that whole byte.
- R11: While `cs_n` is high, SCK is low and every output enable is low. This is also the state after reset.
- R12: `tx_pop` pulses exactly once for each instruction, address and payload byte, on the clock edge where `wr_data` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command; sampled only when idle |
| mode | input | 3 | Lane-plan code (see R1) |
| op_len | input | LEN_W | Instruction byte count |
| ad_len | input | LEN_W | Address byte count |
| wr_len | input | LEN_W | Outgoing payload byte count |
| hz_len | input | LEN_W | Dummy byte count, mode byte included |
| rd_len | input | LEN_W | Incoming read byte count |
| mode_byte | input | 8 | Optional mode byte, sent when nonzero |
| wr_data | input | 8 | Head of the outgoing byte stream |
| tx_pop | output | 1 | Stream head consumed at this edge |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| busy | output | 1 | Command in progress |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
On every cycle the assertions check the idle quietness of the bus, that `cs_n` is only released after a low SCK, that `busy` covers the whole chip-select window, that the latched settings stay frozen while a second `start` arrives, and that no lane is driven in a cycle that delivers a read byte. Other properties need whole commands, and only the bench scenarios can show them: the exact lane and bit placement per mode, the dummy edge count for each lane width, the mode-byte insertion, the pop count, and the read byte order. A flash model in the bench replays the expected lane schedule edge by edge.

// File: rtl/mio_spi_pkg.sv
// Shared types for the multi-lane serial flash command sequencer.
// Assumes lane counts are encoded as log2 (0 = 1 lane, 1 = 2, 2 = 4).
package mio_spi_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_HOLD
    } seq_state_t;

    // Lane counts (log2) for the three groups of a command.
    typedef struct packed {
        logic [1:0] op_wl;
        logic [1:0] ad_wl;
        logic [1:0] dt_wl;
    } lane_plan_t;

    // Everything the sequencer needs to know about one byte slot.
    typedef struct packed {
        logic [1:0] wl;
        logic       drive;
        logic       from_stream;
        logic       use_mbyte;
        logic       capture;
        logic       last;
    } byte_info_t;

    // Map the lane-plan code to per-group lane counts; unknown codes fall back to one lane.
    function automatic lane_plan_t plan_for(input logic [2:0] code);
        lane_plan_t p;
        unique case (code)
            3'd1:    p = '{op_wl: 2'd0, ad_wl: 2'd0, dt_wl: 2'd1};
            3'd2:    p = '{op_wl: 2'd0, ad_wl: 2'd1, dt_wl: 2'd1};
            3'd3:    p = '{op_wl: 2'd0, ad_wl: 2'd0, dt_wl: 2'd2};
            3'd4:    p = '{op_wl: 2'd0, ad_wl: 2'd2, dt_wl: 2'd2};
            3'd5:    p = '{op_wl: 2'd2, ad_wl: 2'd2, dt_wl: 2'd2};
            default: p = '{op_wl: 2'd0, ad_wl: 2'd0, dt_wl: 2'd0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mio_byte_classify.sv
`timescale 1ns/1ps
// Classifies one byte slot of a command by its index: which group it belongs
// to, how many lanes it uses, whether the controller drives it, where its
// outgoing value comes from, and whether it is captured as read data.
// Assumes group order instruction, address, payload, dummy, read.
module mio_byte_classify
    import mio_spi_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int IDX_W = LEN_W + 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [LEN_W-1:0] op_len,
    input  logic [LEN_W-1:0] ad_len,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [LEN_W-1:0] hz_len,
    input  logic [LEN_W-1:0] rd_len,
    input  lane_plan_t       plan,
    input  logic             mbyte_nz,
    output byte_info_t       info
);

    logic [IDX_W-1:0] end_op, end_ad, end_wr, end_hz, end_rd;

    // Running end positions of each group.
    always_comb begin
        end_op = IDX_W'(op_len);
        end_ad = end_op + IDX_W'(ad_len);
        end_wr = end_ad + IDX_W'(wr_len);
        end_hz = end_wr + IDX_W'(hz_len);
        end_rd = end_hz + IDX_W'(rd_len);
    end

    // Decode the slot attributes from the group the index falls in.
    always_comb begin
        info = '0;
        if (idx < end_op) begin
            info.wl          = plan.op_wl;
            info.drive       = 1'b1;
            info.from_stream = 1'b1;
        end else if (idx < end_wr) begin
            info.wl          = plan.ad_wl;
            info.drive       = 1'b1;
            info.from_stream = 1'b1;
        end else if (idx < end_hz) begin
            info.wl          = plan.dt_wl;
            info.use_mbyte   = mbyte_nz && (idx == end_wr);
            info.drive       = mbyte_nz && (idx == end_wr);
        end else begin
            info.wl          = plan.dt_wl;
            info.capture     = 1'b1;
        end
        info.last = (idx == end_rd - IDX_W'(1));
    end

endmodule

// File: rtl/mio_lane_mux.sv
`timescale 1ns/1ps
// Maps the head of the transmit shift register onto the active lanes and
// gathers the sampled lane bits right-aligned. The highest active lane
// carries the most significant bit. In one-lane operation data leaves on
// lane 0 and arrives on lane 1. Assumes four physical lanes.
module mio_lane_mux
    import mio_spi_pkg::*;
(
    input  logic [BYTE_W-1:0] tx_head,
    input  logic [1:0]        wl,
    input  logic              drive_en,
    input  logic [LANES-1:0]  io_in,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe,
    output logic [LANES-1:0]  rx_bits
);

    logic [LANES-1:0] window;
    logic [LANES-1:0] active;

    // Select the outgoing bit group and the active lane set for the width.
    always_comb begin
        unique case (wl)
            2'd0:    begin window = {3'b000, tx_head[7]};   active = 4'b0001; end
            2'd1:    begin window = {2'b00, tx_head[7:6]};  active = 4'b0011; end
            default: begin window = tx_head[7:4];           active = 4'b1111; end
        endcase
    end

    // Gather the incoming bits; single-lane input comes from lane 1.
    always_comb begin
        unique case (wl)
            2'd0:    rx_bits = {3'b000, io_in[1]};
            2'd1:    rx_bits = {2'b00, io_in[1:0]};
            default: rx_bits = io_in;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign io_out[l] = window[l] & active[l];
        assign io_oe[l]  = drive_en & active[l];
    end

endmodule

// File: rtl/mio_spi_engine.sv
`timescale 1ns/1ps
// Controller-side serial flash command sequencer (SPI mode 0, SCK = clk/2).
// Runs one command through instruction, address, payload, dummy and read
// bytes, with the per-group lane counts chosen by a lane-plan code.
// Assumes wr_data is a show-ahead stream that advances on tx_pop, and that
// external pads combine io_out/io_oe/io_in.
module mio_spi_engine
    import mio_spi_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [LEN_W-1:0]  op_len,
    input  logic [LEN_W-1:0]  ad_len,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [LEN_W-1:0]  hz_len,
    input  logic [LEN_W-1:0]  rd_len,
    input  logic [7:0]        mode_byte,
    input  logic [7:0]        wr_data,
    output logic              tx_pop,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);

    localparam int IDX_W = LEN_W + 3;

    seq_state_t       st;
    logic             half;
    logic [IDX_W-1:0] bidx;
    logic [2:0]       step;
    logic [BYTE_W-1:0] tx_sh, rx_sh, rx_next, load_byte;
    logic [2:0]       mode_q;
    logic [LEN_W-1:0] op_q, ad_q, wr_q, hz_q, rd_q;
    logic [7:0]       mbyte_q;
    logic [1:0]       cur_wl;
    logic             cur_drive, cur_capture, cur_last;
    logic [IDX_W-1:0] lidx;
    logic [2:0]       steps_m1;
    logic             last_step, boundary, cmd_empty;
    logic [LANES-1:0] rx_bits;
    lane_plan_t       plan;
    byte_info_t       info;

    // Decode of the byte slot about to be loaded (first slot, or the next one).
    assign plan      = plan_for(mode_q);
    assign lidx      = (st == ST_LOAD) ? '0 : bidx + IDX_W'(1);
    assign steps_m1  = 3'd7 >> cur_wl;
    assign last_step = (step == steps_m1);
    assign boundary  = (st == ST_SHIFT) && half && last_step && !cur_last;
    assign cmd_empty = ~|{op_len, ad_len, wr_len, hz_len, rd_len};
    assign load_byte = info.use_mbyte ? mbyte_q : (info.from_stream ? wr_data : 8'h00);
    assign tx_pop    = ((st == ST_LOAD) || boundary) && info.from_stream;
    assign busy      = (st != ST_IDLE);

    mio_byte_classify #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_classify (
        .idx      (lidx),
        .op_len   (op_q),
        .ad_len   (ad_q),
        .wr_len   (wr_q),
        .hz_len   (hz_q),
        .rd_len   (rd_q),
        .plan     (plan),
        .mbyte_nz (mbyte_q != 8'h00),
        .info     (info)
    );

    mio_lane_mux u_lanes (
        .tx_head  (tx_sh),
        .wl       (cur_wl),
        .drive_en ((st == ST_SHIFT) && cur_drive),
        .io_in    (io_in),
        .io_out   (io_out),
        .io_oe    (io_oe),
        .rx_bits  (rx_bits)
    );

    // Shift the sampled lane bits into the receive byte, MSB first.
    always_comb begin
        unique case (cur_wl)
            2'd0:    rx_next = {rx_sh[6:0], rx_bits[0]};
            2'd1:    rx_next = {rx_sh[5:0], rx_bits[1:0]};
            default: rx_next = {rx_sh[3:0], rx_bits[3:0]};
        endcase
    end

    // Command sequencer: framing, SCK generation, byte and step counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            half        <= 1'b0;
            bidx        <= '0;
            step        <= '0;
            tx_sh       <= '0;
            rx_sh       <= '0;
            sck         <= 1'b0;
            cs_n        <= 1'b1;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            mode_q      <= '0;
            op_q        <= '0;
            ad_q        <= '0;
            wr_q        <= '0;
            hz_q        <= '0;
            rd_q        <= '0;
            mbyte_q     <= '0;
            cur_wl      <= '0;
            cur_drive   <= 1'b0;
            cur_capture <= 1'b0;
            cur_last    <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start && !cmd_empty) begin
                        mode_q  <= mode;
                        op_q    <= op_len;
                        ad_q    <= ad_len;
                        wr_q    <= wr_len;
                        hz_q    <= hz_len;
                        rd_q    <= rd_len;
                        mbyte_q <= mode_byte;
                        st      <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cs_n        <= 1'b0;
                    bidx        <= lidx;
                    step        <= '0;
                    half        <= 1'b0;
                    tx_sh       <= load_byte;
                    cur_wl      <= info.wl;
                    cur_drive   <= info.drive;
                    cur_capture <= info.capture;
                    cur_last    <= info.last;
                    st          <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (!half) begin
                        sck   <= 1'b1;
                        half  <= 1'b1;
                        rx_sh <= rx_next;
                        if (last_step && cur_capture) begin
                            rd_data  <= rx_next;
                            rd_valid <= 1'b1;
                        end
                    end else begin
                        sck  <= 1'b0;
                        half <= 1'b0;
                        if (!last_step) begin
                            step <= step + 3'd1;
                            unique case (cur_wl)
                                2'd0:    tx_sh <= tx_sh << 1;
                                2'd1:    tx_sh <= tx_sh << 2;
                                default: tx_sh <= tx_sh << 4;
                            endcase
                        end else if (cur_last) begin
                            st <= ST_HOLD;
                        end else begin
                            bidx        <= lidx;
                            step        <= '0;
                            tx_sh       <= load_byte;
                            cur_wl      <= info.wl;
                            cur_drive   <= info.drive;
                            cur_capture <= info.capture;
                            cur_last    <= info.last;
                        end
                    end
                end
                ST_HOLD: begin
                    cs_n <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_CS_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (!sck && io_oe == 4'b0000)) else $error("bus active while deselected"); // R11
    AST_CS_RELEASE_LOW_SCK: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> (!sck && $past(!sck))) else $error("chip select released near high SCK"); // R8
    AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy) else $error("chip select low while idle"); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> ($stable(mode_q) && $stable(op_q) && $stable(rd_q) && $stable(hz_q))) else $error("settings changed while busy"); // R9
    AST_RX_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (io_oe == 4'b0000)) else $error("lane driven while receiving"); // R10
    AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid) else $error("read strobe longer than one cycle"); // R6
    AST_POP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> busy) else $error("stream popped while idle"); // R12

endmodule

// File: tb/sim_mio_spi_engine.sv
`timescale 1ns/1ps
// Bench: a vector table of commands walked by one loop, then directed tests.
module sim_mio_spi_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] mode = '0;
    logic [7:0] op_len = '0, ad_len = '0, wr_len = '0, hz_len = '0, rd_len = '0;
    logic [7:0] mode_byte = '0;
    logic [7:0] wr_data;
    logic       tx_pop;
    logic [7:0] rd_data;
    logic       rd_valid, busy, sck, cs_n;
    logic [3:0] io_out, io_oe;
    logic [3:0] io_in = '0;

    int nchk = 0, nbad = 0;

    always #4 clk = ~clk;

    mio_spi_engine #(.LEN_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_len(op_len), .ad_len(ad_len), .wr_len(wr_len), .hz_len(hz_len), .rd_len(rd_len),
        .mode_byte(mode_byte), .wr_data(wr_data), .tx_pop(tx_pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .sck(sck), .cs_n(cs_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // {mode, instr, addr, payload, dummy, read, mode byte}
    localparam int NV = 12;
    localparam logic [50:0] VECS [NV] = '{
        {3'd0, 8'd1, 8'd3, 8'd0, 8'd0, 8'd2, 8'h00},
        {3'd1, 8'd1, 8'd3, 8'd0, 8'd1, 8'd3, 8'h00},
        {3'd2, 8'd1, 8'd3, 8'd0, 8'd1, 8'd2, 8'hA0},
        {3'd3, 8'd1, 8'd3, 8'd0, 8'd1, 8'd2, 8'h00},
        {3'd4, 8'd1, 8'd3, 8'd0, 8'd3, 8'd4, 8'h20},
        {3'd5, 8'd1, 8'd3, 8'd0, 8'd2, 8'd2, 8'h00},
        {3'd1, 8'd1, 8'd3, 8'd2, 8'd0, 8'd0, 8'h00},
        {3'd4, 8'd1, 8'd3, 8'd4, 8'd0, 8'd0, 8'h00},
        {3'd0, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'h00},
        {3'd6, 8'd1, 8'd1, 8'd0, 8'd0, 8'd1, 8'h00},
        {3'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2, 8'h00},
        {3'd0, 8'd1, 8'd3, 8'd0, 8'd1, 8'd1, 8'h5C}
    };

    function automatic logic [7:0] sb(input int i);
        return 8'h5A ^ 8'(i * 37 + 1);
    endfunction

    function automatic logic [7:0] rb(input int i);
        return 8'(8'hC3 + i * 29);
    endfunction

    // Lane count (log2) per group from the R1 table: g 0 instr, 1 addr/payload, 2 dummy/read.
    function automatic int bwl(input logic [2:0] m, input int g);
        case (m)
            3'd1: return (g == 2) ? 1 : 0;
            3'd2: return (g == 0) ? 0 : 1;
            3'd3: return (g == 2) ? 2 : 0;
            3'd4: return (g == 0) ? 0 : 2;
            3'd5: return 2;
            default: return 0;
        endcase
    endfunction

    // Outgoing stream: show-ahead, advances on tx_pop.
    int wr_ptr = 0, wr_base = 0;
    always @(posedge clk) if (tx_pop) wr_ptr <= wr_ptr + 1;
    assign wr_data = sb(wr_ptr - wr_base);

    // Expected per-edge schedule.
    logic [3:0] ex_mask [256];
    logic [3:0] ex_bits [256];
    logic [3:0] ex_in   [256];
    int E = 0;

    // Monitor counters.
    int edges, oe_err, rcv, rd_err, cs_low, busy_cnt, idle_bad;
    logic prev_sck = 1'b0;

    task automatic clr();
        edges = 0; oe_err = 0; rcv = 0; rd_err = 0; cs_low = 0; busy_cnt = 0; idle_bad = 0;
        wr_base = wr_ptr;
    endtask

    // Flash model and bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (sck && !prev_sck) begin
            if (edges < E) begin
                if (io_oe !== ex_mask[edges]) oe_err++;
                else if ((io_out & ex_mask[edges]) !== ex_bits[edges]) oe_err++;
            end else begin
                oe_err++;
            end
            edges++;
        end
        prev_sck = sck;
        if (!cs_n) cs_low++;
        if (busy) busy_cnt++;
        if (cs_n && (sck || io_oe != 4'b0000)) idle_bad++;
        if (rd_valid) begin
            if (rd_data !== rb(rcv)) rd_err++;
            rcv++;
        end
        if (!sck) io_in = (edges < E) ? ex_in[edges] : 4'h0;
    end

    task automatic build(input logic [50:0] v);
        logic [2:0] m;
        int op, ad, wr, hz, rd, e, si, ri;
        logic [7:0] mb;
        m = v[50:48]; op = v[47:40]; ad = v[39:32]; wr = v[31:24];
        hz = v[23:16]; rd = v[15:8]; mb = v[7:0];
        e = 0; si = 0; ri = 0;
        for (int b = 0; b < op + ad + wr + hz + rd; b++) begin
            int wl, w, steps;
            logic drv, cap;
            logic [7:0] val;
            logic [3:0] msk;
            cap = 1'b0; drv = 1'b0; val = 8'h00;
            if (b < op) begin wl = bwl(m, 0); drv = 1'b1; val = sb(si); si++; end
            else if (b < op + ad + wr) begin wl = bwl(m, 1); drv = 1'b1; val = sb(si); si++; end
            else if (b < op + ad + wr + hz) begin
                wl = bwl(m, 2);
                if (b == op + ad + wr && mb != 8'h00) begin drv = 1'b1; val = mb; end
            end else begin wl = bwl(m, 2); cap = 1'b1; val = rb(ri); ri++; end
            w = 1 << wl; steps = 8 / w; msk = 4'((1 << w) - 1);
            for (int s = 0; s < steps; s++) begin
                logic [3:0] bits;
                bits = 4'((val >> (8 - w * (s + 1)))) & msk;
                ex_mask[e] = drv ? msk : 4'h0;
                ex_bits[e] = drv ? bits : 4'h0;
                if (cap) begin
                    if (w == 1) ex_in[e] = {2'b11, bits[0], ~bits[0]};
                    else if (w == 2) ex_in[e] = {2'b10, bits[1:0]};
                    else ex_in[e] = bits;
                end else begin
                    ex_in[e] = 4'hA ^ 4'(e);
                end
                e++;
            end
        end
        E = e;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [50:0] v);
        mode = v[50:48]; op_len = v[47:40]; ad_len = v[39:32]; wr_len = v[31:24];
        hz_len = v[23:16]; rd_len = v[15:8]; mode_byte = v[7:0];
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        E = 0;
        clr();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: R11 quiet bus, R8 not busy.
        chk(cs_n === 1'b1 && sck === 1'b0 && io_oe === 4'h0, "R11 reset bus quiet", int'({cs_n, sck, io_oe}), 32);
        chk(busy === 1'b0 && rd_valid === 1'b0, "R8 reset not busy", int'({busy, rd_valid}), 0);

        // Vector table walk.
        for (int k = 0; k < NV; k++) begin
            logic [50:0] v;
            v = VECS[k];
            build(v);
            apply(v);
            clr();
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            wait_idle();
            chk(edges == E, $sformatf("R4 R7 sck edges vec %0d", k), edges, E);
            chk(oe_err == 0, $sformatf("R1 R2 R3 R5 R10 lane drive vec %0d", k), oe_err, 0);
            chk(rcv == int'(v[15:8]) && rd_err == 0, $sformatf("R6 read bytes vec %0d (data errs %0d)", k, rd_err), rcv, int'(v[15:8]));
            chk(wr_ptr - wr_base == int'(v[47:40]) + int'(v[39:32]) + int'(v[31:24]),
                $sformatf("R12 pops vec %0d", k), wr_ptr - wr_base,
                int'(v[47:40]) + int'(v[39:32]) + int'(v[31:24]));
            chk(cs_low == 2 * E + 1 && busy_cnt == 2 * E + 2, $sformatf("R8 framing vec %0d (busy %0d)", k, busy_cnt), cs_low, 2 * E + 1);
            chk(idle_bad == 0, $sformatf("R11 idle quiet vec %0d", k), idle_bad, 0);
        end

        // R7: empty command makes no bus activity.
        E = 0;
        apply({3'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'h00});
        clr();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy_cnt == 0 && cs_low == 0 && edges == 0, "R7 empty command idle", busy_cnt + cs_low + edges, 0);

        // R9: second start while busy is ignored; settings stay latched.
        build(VECS[0]);
        apply(VECS[0]);
        clr();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (6) @(negedge clk);
        apply({3'd5, 8'd2, 8'd4, 8'd1, 8'd2, 8'd3, 8'h77});
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(edges == E, "R9 ignored start edge count", edges, E);
        chk(oe_err == 0 && rcv == 2 && rd_err == 0, "R9 ignored start lane data", oe_err + rd_err, 0);
        chk(cs_low == 2 * E + 1 && !busy, "R9 no second command", cs_low, 2 * E + 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule